// File: doc/BRIEF.md
# UART Enhanced Register Access Unit

This block decodes the CPU register bus of a 16550-style UART for the registers that sit outside the FIFOs and the serial engine. These are the line control byte, the scratch byte, and a hidden bank that opens only while the line control byte holds the key value 0xBF. The hidden bank holds a feature control byte and a dual-purpose trigger register. A write to the trigger register sets a FIFO trigger level. A read of the same register returns a live FIFO occupancy count.

When feature control bit 6 is set, the scratch address changes role. Its reads return FIFO counts, and its writes (bank open only) land in a write-only enhanced mode byte. The enhanced mode byte picks the count returned: receive, transmit, or an alternating sequence in which each read flips between receive and transmit and bit 7 flags which one was returned. The block exports both trigger levels and a 4-bit RTS hysteresis code to the flow-control logic, which is outside this block.

Top module: `uart_xreg_unit`

## Requirements
- R1: After a synchronous active-low reset, the line control, scratch, feature control and enhanced mode bytes are 0. Both trigger levels are 1, and the alternating read sequence starts on receive.
- R2: The line control byte is read and written at address 3 whatever its value.
- R3: Addresses 0 (trigger/count) and 1 (feature control) respond only while the line control byte equals 0xBF. Otherwise, writes to them change nothing and reads of them return 0. With the bank open, address 1 reads back the feature control byte.
- R4: A write to address 0 with the bank open sets the receive trigger when feature control bit 7 is 0, and the transmit trigger when it is 1. Values above 128 saturate to 128, and the other trigger is left unchanged.
- R5: A read of address 0 with the bank open returns, zero-extended, the receive FIFO count when feature control bit 7 is 0 and the transmit FIFO count when it is 1.
- R6: With feature control bit 6 at 0, address 7 is a plain read/write storage byte under any line control value.
- R7: With feature control bit 6 at 1 and the bank open, a write to address 7 loads the enhanced mode byte and leaves the storage byte untouched. The enhanced mode byte cannot be read back.
- R8: With feature control bit 6 at 1 and the bank closed, a write to address 7 changes neither the storage byte nor the enhanced mode byte.
- R9: With feature control bit 6 at 1, a read of address 7 returns a FIFO count under any line control value. The count is the receive count when enhanced mode bit 0 is 0 and the transmit count when it is 1, unless R10 applies.
- R10: When enhanced mode bits 1:0 are both 1, reads of address 7 return {flag, count[6:0]}. The flag is 0 with the receive count and 1 with the transmit count. The sequence starts on receive, flips once per read strobe, and returns to receive on every enhanced mode write.
- R11: The hysteresis code output equals {enhanced mode bits 5:4, feature control bits 1:0}.
- R12: Addresses 2, 4, 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, 0 otherwise |
| rx_count | input | 7 | Receive FIFO occupancy |
| tx_count | input | 7 | Transmit FIFO occupancy |
| rx_trig | output | 8 | Programmed receive trigger level |
| tx_trig | output | 8 | Programmed transmit trigger level |
| hyst_code | output | 4 | RTS hysteresis select code |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that each strobe counts as one access per cycle it is high, so a read held for several cycles would advance the alternation several times. The bench drives every access as a one-cycle pulse launched on the falling edge, and never overlaps the two strobes. The FIFO counts are assumed to stay within the FIFO depth so that bit 7 is free for the alternation flag. The bench sweeps counts only from 0 to 64.

// File: rtl/uart_xreg_pkg.sv
// Package: shared address map and widths for the enhanced register unit.
// Assumes a 3-bit register address space as in a 16550-style UART.
package uart_xreg_pkg;
    localparam logic [2:0] A_TRGCNT = 3'd0;   // bank: trigger write / count read
    localparam logic [2:0] A_FEAT   = 3'd1;   // bank: feature control
    localparam logic [2:0] A_LINE   = 3'd3;   // line control
    localparam logic [2:0] A_SCR    = 3'd7;   // scratch / count / enhanced mode
    localparam logic [7:0] BANK_KEY = 8'hBF;  // line value that opens the bank

    // Feature control bit positions used by the decoder
    localparam int F_SCR_SWAP = 6;
    localparam int F_TX_SEL   = 7;
endpackage

// File: rtl/uart_xreg_regs.sv
// Module: register storage for line, scratch, feature control, enhanced
// mode and both trigger levels. Applies bank gating on writes.
// Assumes bus_wr is a one-cycle strobe and never overlaps a read.
module uart_xreg_regs
    import uart_xreg_pkg::*;
#(
    parameter int TRIG_MAX  = 128,
    parameter int TRIG_INIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] line_q,
    output logic [7:0] scr_q,
    output logic [7:0] feat_q,
    output logic [7:0] emode_q,
    output logic [7:0] rx_trig_q,
    output logic [7:0] tx_trig_q,
    output logic       emode_wr
);
    localparam logic [7:0] TMAX  = 8'(TRIG_MAX);
    localparam logic [7:0] TINIT = 8'(TRIG_INIT);

    logic       bank_open;
    logic       scr_swap;
    logic [7:0] trig_val;

    // Decode write targets from the current bank and swap state
    always_comb begin
        bank_open = (line_q == BANK_KEY);
        scr_swap  = feat_q[F_SCR_SWAP];
        emode_wr  = wr && (addr == A_SCR) && scr_swap && bank_open;
        trig_val  = (wdata > TMAX) ? TMAX : wdata;
    end

    // Update the control bytes on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            scr_q   <= '0;
            feat_q  <= '0;
            emode_q <= '0;
        end else if (wr) begin
            if (addr == A_LINE)
                line_q <= wdata;
            if (addr == A_FEAT && bank_open)
                feat_q <= wdata;
            if (addr == A_SCR && !scr_swap)
                scr_q <= wdata;
            if (emode_wr)
                emode_q <= wdata;
        end
    end

    // Load the trigger level chosen by feature bit 7, saturated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig_q <= TINIT;
            tx_trig_q <= TINIT;
        end else if (wr && addr == A_TRGCNT && bank_open) begin
            if (feat_q[F_TX_SEL])
                tx_trig_q <= trig_val;
            else
                rx_trig_q <= trig_val;
        end
    end

    // R3
    closed_bank_feat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_FEAT && line_q != BANK_KEY) |=> $stable(feat_q));
    // R4
    trig_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_trig_q <= TMAX) && (tx_trig_q <= TMAX));
    // R4
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(rx_trig_q) && $stable(tx_trig_q)));
    // R8
    closed_bank_emode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SCR && line_q != BANK_KEY) |=> $stable(emode_q));
endmodule

// File: rtl/uart_xreg_alt.sv
// Module: receive/transmit alternation flag for scratch count reads.
// Assumes adv and clr are single-cycle qualified strobes; clr wins.
module uart_xreg_alt (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    output logic alt_tx
);
    // Flip on each counted read, return to receive on mode write
    always_ff @(posedge clk) begin
        if (!rst_n)
            alt_tx <= 1'b0;
        else if (clr)
            alt_tx <= 1'b0;
        else if (adv)
            alt_tx <= ~alt_tx;
    end
endmodule

// File: rtl/uart_xreg_rdmux.sv
// Module: read data steering for every address of the unit.
// Assumes count width leaves bit 7 free for the alternation flag.
module uart_xreg_rdmux
    import uart_xreg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             rd,
    input  logic [2:0]       addr,
    input  logic [7:0]       line_q,
    input  logic [7:0]       scr_q,
    input  logic [7:0]       feat_q,
    input  logic [7:0]       emode_q,
    input  logic             alt_tx,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic [7:0]       rdata
);
    localparam int PAD = 8 - CNT_W;

    logic [7:0] rx_ext;
    logic [7:0] tx_ext;
    logic [7:0] scr_cnt;
    logic [7:0] alt_cnt;
    logic       bank_open;

    // Build the count forms the scratch and trigger addresses can return
    always_comb begin
        rx_ext    = {{PAD{1'b0}}, rx_count};
        tx_ext    = {{PAD{1'b0}}, tx_count};
        alt_cnt   = alt_tx ? {1'b1, tx_ext[6:0]} : {1'b0, rx_ext[6:0]};
        bank_open = (line_q == BANK_KEY);
        if (emode_q[1:0] == 2'b11)
            scr_cnt = alt_cnt;
        else
            scr_cnt = emode_q[0] ? tx_ext : rx_ext;
    end

    // Select the read value for the addressed register
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                A_TRGCNT: rdata = bank_open ? (feat_q[F_TX_SEL] ? tx_ext : rx_ext) : 8'h00;
                A_FEAT:   rdata = bank_open ? feat_q : 8'h00;
                A_LINE:   rdata = line_q;
                A_SCR:    rdata = feat_q[F_SCR_SWAP] ? scr_cnt : scr_q;
                default:  rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/uart_xreg_unit.sv
// Module: top of the UART enhanced register access unit. Ties storage,
// alternation flag and read steering together and exports trigger levels
// and the RTS hysteresis code. Assumes rd and wr never overlap.
module uart_xreg_unit
    import uart_xreg_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int TRIG_MAX   = 128,
    parameter int TRIG_INIT  = 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic [7:0]       rx_trig,
    output logic [7:0]       tx_trig,
    output logic [3:0]       hyst_code
);
    logic [7:0] line_q, scr_q, feat_q, emode_q;
    logic       emode_wr;
    logic       alt_tx;
    logic       alt_adv;

    uart_xreg_regs #(.TRIG_MAX(TRIG_MAX), .TRIG_INIT(TRIG_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .line_q(line_q), .scr_q(scr_q), .feat_q(feat_q), .emode_q(emode_q),
        .rx_trig_q(rx_trig), .tx_trig_q(tx_trig), .emode_wr(emode_wr)
    );

    // Count an alternation step on each swapped scratch read in mode 11
    always_comb begin
        alt_adv = bus_rd && (bus_addr == A_SCR) && feat_q[F_SCR_SWAP]
                  && (emode_q[1:0] == 2'b11);
    end

    uart_xreg_alt u_alt (
        .clk(clk), .rst_n(rst_n), .adv(alt_adv), .clr(emode_wr), .alt_tx(alt_tx)
    );

    uart_xreg_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .rd(bus_rd), .addr(bus_addr), .line_q(line_q), .scr_q(scr_q),
        .feat_q(feat_q), .emode_q(emode_q), .alt_tx(alt_tx),
        .rx_count(rx_count), .tx_count(tx_count), .rdata(bus_rdata)
    );

    // Form the hysteresis code from its two fields
    always_comb begin
        hyst_code = {emode_q[5:4], feat_q[1:0]};
    end

    // R10
    alt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SCR && feat_q[F_SCR_SWAP] && line_q == BANK_KEY) |=> !alt_tx);
    // R3
    closed_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_TRGCNT && line_q != BANK_KEY) |-> (bus_rdata == 8'h00));
    // R11
    hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(hyst_code));
    // R10
    alt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_adv && !bus_wr) |=> (alt_tx != $past(alt_tx)));
endmodule

// File: tb/uart_xreg_unit_tb.sv
module uart_xreg_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] rx_count = '0;
    logic [6:0] tx_count = '0;
    logic [7:0] rx_trig, tx_trig;
    logic [3:0] hyst_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    uart_xreg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_count(rx_count), .tx_count(tx_count), .rx_trig(rx_trig),
        .tx_trig(tx_trig), .hyst_code(hyst_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int sat(input int v);
        return (v > 128) ? 128 : v;
    endfunction

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int exp_rx;
        int exp_tx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 rx_trig", rx_trig, 1);
        check("R1 tx_trig", tx_trig, 1);
        check("R1 hyst", hyst_code, 0);
        rd(3'd3, d); check("R1 line", d, 0);
        rd(3'd7, d); check("R1 scratch", d, 0);

        // R2 R3 R12: sweep every closed-bank line value
        for (int v = 0; v < 256; v++) begin
            if (v == 8'hBF) continue;
            wr(3'd3, 8'(v));
            wr(3'd0, 8'h33);
            wr(3'd1, 8'hFF);
            rd(3'd3, d); check("R2 line readback", d, v);
            rd(3'd0, d); check("R3 closed trg read", d, 0);
            rd(3'd1, d); check("R3 closed feat read", d, 0);
        end
        check("R3 closed rx_trig", rx_trig, 1);
        check("R3 closed tx_trig", tx_trig, 1);
        wr(3'd3, 8'hBF);
        rd(3'd1, d); check("R3 feat untouched", d, 0);
        wr(3'd1, 8'h82);
        rd(3'd1, d); check("R3 feat readback", d, 8'h82);
        foreach (d[i]) ; // no-op
        for (int a = 2; a < 7; a++) begin
            if (a == 3) continue;
            rd(3'(a), d); check("R12 unused addr", d, 0);
        end

        // R4 trigger sweep for both targets
        exp_rx = 1; exp_tx = 1;
        wr(3'd1, 8'h00);
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 8'(v));
            exp_rx = sat(v);
            @(negedge clk);
            check("R4 rx_trig", rx_trig, exp_rx);
            check("R4 tx_trig kept", tx_trig, exp_tx);
        end
        wr(3'd1, 8'h80);
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 8'(v));
            exp_tx = sat(v);
            @(negedge clk);
            check("R4 tx_trig", tx_trig, exp_tx);
            check("R4 rx_trig kept", rx_trig, exp_rx);
        end

        // R5 count read via trigger address
        for (int c = 0; c <= 64; c++) begin
            rx_count = 7'(c); tx_count = 7'(64 - c);
            wr(3'd1, 8'h00);
            rd(3'd0, d); check("R5 rx count", d, c);
            wr(3'd1, 8'h80);
            rd(3'd0, d); check("R5 tx count", d, 64 - c);
        end

        // R6 plain scratch under normal line value
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h03);
        wr(3'd7, 8'hA5);
        rd(3'd7, d); check("R6 scratch", d, 8'hA5);

        // R7 R9 swapped scratch
        rx_count = 7'd5; tx_count = 7'd9;
        wr(3'd3, 8'hBF);
        wr(3'd1, 8'h40);
        wr(3'd7, 8'h01);
        rd(3'd7, d); check("R9 tx count bank open", d, 9);
        wr(3'd3, 8'h03);
        rd(3'd7, d); check("R9 tx count bank closed", d, 9);
        // R8 write ignored while bank closed
        wr(3'd7, 8'h00);
        rd(3'd7, d); check("R8 emode kept", d, 9);
        wr(3'd3, 8'hBF);
        wr(3'd7, 8'h00);
        rd(3'd7, d); check("R9 rx count", d, 5);
        wr(3'd1, 8'h00);
        rd(3'd7, d); check("R7 scratch untouched", d, 8'hA5);

        // R10 alternation
        wr(3'd1, 8'h40);
        wr(3'd7, 8'h03);
        rd(3'd7, d); check("R10 first rx", d, 8'h05);
        rd(3'd7, d); check("R10 then tx", d, 8'h89);
        rd(3'd7, d); check("R10 rx again", d, 8'h05);
        wr(3'd7, 8'h03);
        rd(3'd7, d); check("R10 restart rx", d, 8'h05);
        wr(3'd3, 8'h03);
        rd(3'd7, d); check("R10 tx bank closed", d, 8'h89);
        wr(3'd3, 8'hBF);
        wr(3'd7, 8'h02);
        rd(3'd7, d); check("R9 mode 10 rx", d, 5);
        rd(3'd7, d); check("R9 mode 10 still rx", d, 5);

        // R11 hysteresis code sweep
        for (int c = 0; c < 16; c++) begin
            wr(3'd1, 8'h40 | 8'(c & 3));
            wr(3'd7, 8'((c >> 2) << 4));
            @(negedge clk);
            check("R11 hyst", hyst_code, c);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule